// File: doc/BRIEF.md
# Dual-Edge Match PWM Timer

This block is a free-running up-counter with seven compare values. Together they drive six pulse-width outputs that share one repetition period. Compare value 0 sets the period: when the count equals it, the count returns to zero on the next clock. Each output has two modes. In single-edge mode the output rises at count zero and falls at its own compare value. In double-edge mode one compare value sets the output and another clears it, which gives either a positive or a negative pulse.

Software writes the compare values into shadow registers. A shadow value becomes active only when the period wraps, and only if that register's latch bit is set, so a cycle in progress is never disturbed. Each compare value can raise a sticky interrupt flag. A control bit is driven out as `en_o`. Counting itself is gated by the `ext_en_i` input. A master instance routes its `en_o` to the `ext_en_i` of itself and of a slave instance, so both counters start on the same clock.

Top module: `pwm_match_timer`

## Requirements
- R1: While `ext_en_i` is 1 and the hold bit is 0, `count_o` increases by one per clock. While `ext_en_i` is 0 it keeps its value.
- R2: When a running count equals active compare 0, the next count is 0, so the period is compare0+1 clocks.
- R3: In single-edge mode, output n (n=1..6) is 1 from count 0 and goes to 0 at the count equal to active compare n. A compare n of 0 keeps the output at 0. A compare n above compare 0 keeps it at 1.
- R4: In double-edge mode, output n goes to 1 at count = compare n-1 and to 0 at count = compare n, and holds its level in between. When both values are equal, clearing wins. A set value below the clear value gives a positive pulse; a clear value below the set value gives a negative pulse.
- R5: Writes to addresses 0..6 load shadow compare values. Shadow n moves to active n only when the count wraps and latch bit n of address 9 is 1. Until then the outputs are unaffected by the write.
- R6: Bit n-1 of address 11 enables output n. A disabled output is 0.
- R7: When the count equals active compare k while running and enable bit k of address 12 is set, flag k is set. It stays set until a 1 is written to bit k of address 13. `irq_o` is the OR of all flags. A set and a clear in the same cycle leave the flag set.
- R8: Bit 0 of address 8 is driven on `en_o`.
- R9: While bit 1 of address 8 is 1, the count is held at 0.
- R10: After reset, the count, the flags, `en_o` and all outputs are 0.
- R11: Bit n-1 of address 10 selects double-edge mode (1) or single-edge mode (0) for output n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | CNT_W | Write data |
| ext_en_i | input | 1 | Count enable (from a master's en_o) |
| en_o | output | 1 | Master enable control bit |
| count_o | output | CNT_W | Current count |
| pwm_o | output | 6 | Outputs 1..6 on bits 0..5 |
| irq_flags_o | output | 7 | Sticky match flags |
| irq_o | output | 1 | Any flag set |

## Verification
The hardest situations to reach from the ports are collisions at the wrap cycle. These are a shadow write, a latch-bit change or a flag clear that lands on the same clock as the compare-0 match, and equal set and clear values in double-edge mode. Seeded random epochs reprogram all seven compare values with small values, so periods are short and wraps are frequent. Single-cycle writes are scattered through each epoch so that many of them coincide with a wrap. A directed setup then places a compare value at zero, one beyond the period, an equal set/clear pair and a negative pulse. It also loads shadows with latching disabled and then enabled.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_MR  = 7;
  localparam int NUM_OUT = NUM_MR - 1;
  localparam int ADDR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd8,
    A_LATCH = 4'd9,
    A_MODE  = 4'd10,
    A_OE    = 4'd11,
    A_IE    = 4'd12,
    A_ICLR  = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign run_o  = en_i & ~hold_i;
  assign wrap_o = run_o & (cnt_q == period_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (run_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  // R1
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !wrap_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R1
  count_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !hold_i) |=> $stable(cnt_q));
  // R9
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [CNT_W-1:0]             wr_data_i,
  input  logic                         wrap_i,
  input  logic [NUM_MR-1:0]            match_i,
  output logic [NUM_MR-1:0][CNT_W-1:0] act_o,
  output logic [NUM_OUT-1:0]           mode_o,
  output logic [NUM_OUT-1:0]           oe_o,
  output logic [NUM_MR-1:0]            flags_o,
  output logic                         en_o,
  output logic                         hold_o
);
  logic [NUM_MR-1:0][CNT_W-1:0] shd_q, act_q;
  logic [NUM_MR-1:0]            latch_q, ie_q, flags_q, clr_v;
  logic [NUM_OUT-1:0]           mode_q, oe_q;
  logic                         en_q, hold_q;

  assign clr_v = (wr_en_i && wr_addr_i == A_ICLR) ? wr_data_i[NUM_MR-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q   <= '0;
      latch_q <= '0;
      ie_q    <= '0;
      mode_q  <= '0;
      oe_q    <= '0;
      en_q    <= 1'b0;
      hold_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (int'(wr_addr_i) < NUM_MR) shd_q[wr_addr_i] <= wr_data_i;
      case (wr_addr_i)
        A_CTRL:  begin en_q <= wr_data_i[0]; hold_q <= wr_data_i[1]; end
        A_LATCH: latch_q <= wr_data_i[NUM_MR-1:0];
        A_MODE:  mode_q  <= wr_data_i[NUM_OUT-1:0];
        A_OE:    oe_q    <= wr_data_i[NUM_OUT-1:0];
        A_IE:    ie_q    <= wr_data_i[NUM_MR-1:0];
        default: ;
      endcase
    end
  end

  // shadow to active transfer only on wrap
  for (genvar k = 0; k < NUM_MR; k++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    act_q[k] <= '0;
      else if (wrap_i && latch_q[k])  act_q[k] <= shd_q[k];
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_v) | (match_i & ie_q);
  end

  assign act_o   = act_q;
  assign mode_o  = mode_q;
  assign oe_o    = oe_q;
  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign hold_o  = hold_q;

  // R5
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_q));
  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(flags_q) & ~$past(clr_v)) & ~flags_q) == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic dbl_i,
  input  logic oe_i,
  input  logic at_start_i,
  input  logic set_hit_i,
  input  logic rst_hit_i,
  output logic pwm_o
);
  logic lvl_q, lvl_d, set_c;

  assign set_c = dbl_i ? set_hit_i : at_start_i;
  // clear has priority over set
  assign lvl_d = rst_hit_i ? 1'b0 : (set_c ? 1'b1 : lvl_q);
  assign pwm_o = oe_i & lvl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lvl_q <= 1'b0;
    else if (run_i) lvl_q <= lvl_d;
  end

  // R4
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && rst_hit_i) |=> !lvl_q);
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic               ext_en_i,
  output logic               en_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [NUM_OUT-1:0] pwm_o,
  output logic [NUM_MR-1:0]  irq_flags_o,
  output logic               irq_o
);
  logic [NUM_MR-1:0][CNT_W-1:0] act;
  logic [NUM_OUT-1:0]           mode, oe;
  logic [NUM_MR-1:0]            hit, match;
  logic [CNT_W-1:0]             cnt;
  logic                         run, wrap, hold;

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ext_en_i),
    .hold_i  (hold),
    .period_i(act[0]),
    .cnt_o   (cnt),
    .run_o   (run),
    .wrap_o  (wrap)
  );

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .wrap_i   (wrap),
    .match_i  (match),
    .act_o    (act),
    .mode_o   (mode),
    .oe_o     (oe),
    .flags_o  (irq_flags_o),
    .en_o     (en_o),
    .hold_o   (hold)
  );

  for (genvar k = 0; k < NUM_MR; k++) begin : g_cmp
    assign hit[k]   = (cnt == act[k]);
    assign match[k] = hit[k] & run;
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_ch
    pwm_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .dbl_i     (mode[j]),
      .oe_i      (oe[j]),
      .at_start_i(cnt == '0),
      .set_hit_i (hit[j]),
      .rst_hit_i (hit[j+1]),
      .pwm_o     (pwm_o[j])
    );
  end

  assign count_o = cnt;
  assign irq_o   = |irq_flags_o;

  // R6
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_o & ~oe) == '0));
  // R2
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt <= act[0]) || !$stable(act[0]) || (cnt == '0) || $past(hold));
endmodule

// File: tb/pwm_match_timer_tb.sv
`timescale 1ns/1ps
module pwm_match_timer_tb;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic        ext_en = 0;
  logic        en_o, irq_o;
  logic [15:0] count_o;
  logic [5:0]  pwm_o;
  logic [6:0]  flags_o;

  int checks = 0, errors = 0;

  // reference state
  int        m_shd[7], m_act[7], m_cnt;
  logic [6:0] m_latch, m_ie, m_flags;
  logic [5:0] m_mode, m_oe, m_lvl;
  logic       m_en, m_hold;
  bit         first = 1;
  logic       g_en = 0;

  always #2.5 clk = ~clk;

  pwm_match_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ext_en_i(ext_en), .en_o(en_o), .count_o(count_o),
    .pwm_o(pwm_o), .irq_flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic lvl_next(int j);
    logic sh, rh;
    rh = (m_cnt == m_act[j+1]);
    sh = m_mode[j] ? (m_cnt == m_act[j]) : (m_cnt == 0);
    return rh ? 1'b0 : (sh ? 1'b1 : m_lvl[j]);
  endfunction

  task automatic compare();
    string t;
    t = first ? "R10" : (m_hold ? "R9" : ((m_cnt == 0) ? "R2" : "R1"));
    chk(t, count_o, m_cnt);
    chk(first ? "R10" : "R8", en_o, m_en);
    chk(first ? "R10" : "R7", flags_o, m_flags);
    chk("R7 irq", irq_o, |m_flags);
    for (int j = 0; j < 6; j++) begin
      string tg;
      if (first) tg = "R10";
      else if (!m_oe[j]) tg = "R6";
      else tg = m_mode[j] ? "R4 R11" : "R3 R11";
      chk(tg, pwm_o[j], m_oe[j] & lvl_next(j));
    end
    first = 0;
  endtask

  task automatic advance(logic we, logic [3:0] a, logic [15:0] d, logic en);
    logic run, wrap;
    logic [6:0] ev, clr;
    logic [5:0] nl;
    run  = en && !m_hold;
    wrap = run && (m_cnt == m_act[0]);
    for (int k = 0; k < 7; k++) ev[k] = run && (m_cnt == m_act[k]);
    for (int j = 0; j < 6; j++) nl[j] = lvl_next(j);
    clr = (we && a == 4'd13) ? d[6:0] : 7'd0;
    m_flags = (m_flags & ~clr) | (ev & m_ie);
    if (run) m_lvl = nl;
    if (wrap) for (int k = 0; k < 7; k++) if (m_latch[k]) m_act[k] = m_shd[k];
    if (m_hold) m_cnt = 0;
    else if (wrap) m_cnt = 0;
    else if (run) m_cnt = m_cnt + 1;
    if (we) begin
      if (a < 7) m_shd[a] = d;
      case (a)
        4'd8:  begin m_en = d[0]; m_hold = d[1]; end
        4'd9:  m_latch = d[6:0];
        4'd10: m_mode = d[5:0];
        4'd11: m_oe = d[5:0];
        4'd12: m_ie = d[6:0];
        default: ;
      endcase
    end
  endtask

  task automatic cyc(logic we, logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = a; wr_data = d; ext_en = g_en;
    advance(we, a, d, g_en);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    cyc(1, a, d);
  endtask

  task automatic high_count(int n, output int hc);
    hc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      if (pwm_o[5]) hc++;
      wr_en = 0; ext_en = g_en;
      advance(0, 0, 0, g_en);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hc;
    void'($urandom(32'd4242));
    for (int k = 0; k < 7; k++) begin m_shd[k] = 0; m_act[k] = 0; end
    m_cnt = 0; m_latch = 0; m_ie = 0; m_flags = 0; m_mode = 0; m_oe = 0;
    m_lvl = 0; m_en = 0; m_hold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    idle(2);  // R10 reset state checked in first compare

    // R8 enable bit out, then start counting
    wr(4'd8, 16'h1);
    g_en = 1;
    // directed corner setup: period 10
    wr(4'd0, 16'd9);  wr(4'd1, 16'd0);  wr(4'd2, 16'd12); wr(4'd3, 16'd7);
    wr(4'd4, 16'd3);  wr(4'd5, 16'd3);  wr(4'd6, 16'd6);
    wr(4'd11, 16'h3f); wr(4'd10, 16'h3c); wr(4'd12, 16'h7f);
    wr(4'd9, 16'h7f);
    idle(40);
    wr(4'd13, 16'h7f);
    // R5: shadow writes without latch bits leave output 6 alone
    wr(4'd9, 16'h00);
    high_count(10, hc);
    chk("R5 pre", hc, 3);
    wr(4'd5, 16'd1); wr(4'd6, 16'd8);
    idle(25);
    high_count(10, hc);
    chk("R5 unlatched", hc, 3);
    wr(4'd9, 16'h7f);
    idle(20);
    high_count(10, hc);
    chk("R5 latched", hc, 7);
    // R9 hold, R1 pause
    wr(4'd8, 16'h3); idle(5); wr(4'd8, 16'h1);
    g_en = 0; idle(6); g_en = 1; idle(6);

    // random epochs
    for (int e = 0; e < 60; e++) begin
      for (int k = 0; k < 7; k++) wr(k[3:0], 16'($urandom_range(0, 14)));
      wr(4'd10, 16'($urandom_range(0, 63)));
      wr(4'd11, 16'($urandom_range(0, 63)));
      wr(4'd12, 16'($urandom_range(0, 127)));
      wr(4'd9, ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 127)) : 16'h7f);
      for (int i = 0; i < 60; i++) begin
        int r;
        r = $urandom_range(0, 31);
        g_en = ($urandom_range(0, 15) != 0);
        if (r == 0) wr(4'd13, 16'($urandom_range(0, 127)));
        else if (r == 1) wr(3'($urandom_range(0, 6)), 16'($urandom_range(0, 14)));
        else if (r == 2) wr(4'd8, 16'h3);
        else if (r == 3) wr(4'd8, 16'h1);
        else cyc(0, 0, 0);
      end
      wr(4'd8, 16'h1);
    end
    g_en = 1;
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule